// File: doc/BRIEF.md
# Switch Elementwise Reduction Unit

This unit sits in a switch data path and folds together one vector from each member of a group of ingress ports. Every port presents its vector as a stream of 64-bit words under a valid/ready handshake. For each word position the unit waits until every member port offers that word. It then combines the words lane by lane and emits one result word. The finished vector has the same length as each contribution and leaves by one of three routes: whole to a single root port, whole to the multicast replication path, or cut into equal slices with slice i going to port i.

A job is launched with a one-cycle `start` pulse. At that pulse the unit captures the member mask, the operation, the delivery mode, the root port and the byte length. A malformed job is refused with a one-cycle `err` pulse. A successful job ends with a one-cycle `done` pulse.

The controller has four states. `IDLE` waits for `start`. It moves to `RUN` when the request is valid (transition *accept*) and to `REJ` when it is not (transition *refuse*). `RUN` passes one word per cycle whenever every member port and the selected sink are ready. It moves to `FIN` on the handshake of the final word (transition *complete*). `FIN` and `REJ` each last one cycle and then return to `IDLE` (transitions *retire* and *recover*).

Top module: `sru_top`

## Requirements
- R1: A result word is emitted, and the inputs are consumed, only in a cycle where every port in the captured member mask has `in_valid` high. When consumption happens, `in_ready` is high on all member ports in the same cycle.
- R2: A port outside the member mask never sees `in_ready` high, and its data has no effect on any result.
- R3: Each word is four signed 16-bit lanes, and ops are combined in ascending port order. The op codes are: 0 = lane sum, wrapping modulo 2^16; 1 = signed lane maximum; 2 = signed lane minimum; 3 = bitwise AND; 4 = bitwise OR; 5 = bitwise XOR.
- R4: Mode 0 (root) sends every result word, in index order, only on `out_valid[cfg_root]` with the data on `out_data`. `mc_valid` stays low.
- R5: Mode 1 (multicast) sends every result word, unchanged and in index order, on `mc_valid`/`mc_data`. No `out_valid` bit rises.
- R6: Mode 2 (scatter) uses a slice length of words/NPORTS. Result word k goes only to port k / slice length, so port i receives exactly slice i.
- R7: The request is refused if any of these hold: the byte length is zero or not a multiple of 128; the mask is empty; the op code is above 5; the mode is 3. On refusal, `err` is high for exactly the cycle after `start`, no input is consumed and no output is offered.
- R8: `done` is high for exactly one cycle, the cycle after the last result word's handshake.
- R9: While the selected sink holds its ready low, the offered result word stays in place and no input is consumed. Results are unchanged by such stalls.
- R10: After reset there is no valid output and no ready input, and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse; configuration is captured on it |
| cfg_mask | input | NPORTS | Member ports of the group |
| cfg_op | input | 3 | Operation code |
| cfg_mode | input | 2 | Delivery: 0 root, 1 multicast, 2 scatter |
| cfg_root | input | PW | Root port for mode 0 |
| cfg_len_bytes | input | LEN_W | Vector length in bytes |
| in_valid | input | NPORTS | Per-port word valid |
| in_data | input | NPORTS*WORD_W | Per-port words, port p at bits p*WORD_W upward |
| in_ready | output | NPORTS | Per-port word accepted |
| out_valid | output | NPORTS | Result word offered to that port |
| out_data | output | WORD_W | Result word for the port outputs |
| out_ready | input | NPORTS | Per-port result sink ready |
| mc_valid | output | 1 | Result word offered to the multicast path |
| mc_data | output | WORD_W | Result word for the multicast path |
| mc_ready | input | 1 | Multicast path ready |
| busy | output | 1 | High while in `RUN` |
| done | output | 1 | Completion pulse |
| err | output | 1 | Refusal pulse |

## Verification
The bench builds the unit with its defaults: four ports, 64-bit words split into four 16-bit lanes, and a 128-byte granule of sixteen words. With four ports, partial masks that leave a port out can be paired with a junk-driving non-member. With a multi-granule length of 48 words, scatter slices of 12 words are not a power of two and cross granule edges. Staggered per-port valids and alternating sink ready reach the alignment and stall paths. Lane data from mixed-sign seeds drives sums past the 16-bit wrap and sets negative against positive values in max and min.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam logic [2:0] OP_SUM = 3'd0;
    localparam logic [2:0] OP_MAX = 3'd1;
    localparam logic [2:0] OP_MIN = 3'd2;
    localparam logic [2:0] OP_AND = 3'd3;
    localparam logic [2:0] OP_OR  = 3'd4;
    localparam logic [2:0] OP_XOR = 3'd5;

    localparam logic [1:0] DLV_ROOT    = 2'd0;
    localparam logic [1:0] DLV_MCAST   = 2'd1;
    localparam logic [1:0] DLV_SCATTER = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN,
        ST_REJ
    } sru_state_e;

endpackage

// File: rtl/sru_lane_alu.sv
module sru_lane_alu #(
    parameter int WORD_W = 64,
    parameter int LANE_W = 16,
    localparam int NLANES = WORD_W / LANE_W
) (
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);
    import sru_pkg::*;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic signed [LANE_W-1:0] la, lb, lr;
        assign la = a[l*LANE_W +: LANE_W];
        assign lb = b[l*LANE_W +: LANE_W];
        always_comb begin
            case (op)
                OP_SUM:  lr = la + lb;
                OP_MAX:  lr = (la > lb) ? la : lb;
                OP_MIN:  lr = (la < lb) ? la : lb;
                OP_AND:  lr = la & lb;
                OP_OR:   lr = la | lb;
                OP_XOR:  lr = la ^ lb;
                default: lr = la;
            endcase
        end
        assign y[l*LANE_W +: LANE_W] = lr;
    end

endmodule

// File: rtl/sru_combine.sv
module sru_combine #(
    parameter int NPORTS = 4,
    parameter int WORD_W = 64,
    parameter int LANE_W = 16
) (
    input  logic [2:0]               op,
    input  logic [NPORTS-1:0]        mask,
    input  logic [NPORTS*WORD_W-1:0] din,
    output logic [WORD_W-1:0]        y
);
    logic [WORD_W-1:0] acc [NPORTS+1];

    assign acc[0] = '0;

    for (genvar p = 0; p < NPORTS; p++) begin : g_stage
        logic [WORD_W-1:0] word_p, mix_p;
        logic              seen_p;

        assign word_p = din[p*WORD_W +: WORD_W];

        if (p == 0) begin : g_first
            assign seen_p = 1'b0;
        end else begin : g_rest
            assign seen_p = |mask[p-1:0];
        end

        sru_lane_alu #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_alu (
            .op (op),
            .a  (acc[p]),
            .b  (word_p),
            .y  (mix_p)
        );

        assign acc[p+1] = !mask[p] ? acc[p] : (seen_p ? mix_p : word_p);
    end

    assign y = acc[NPORTS];

endmodule

// File: rtl/sru_ctrl.sv
module sru_ctrl #(
    parameter int NPORTS        = 4,
    parameter int WORD_W        = 64,
    parameter int LEN_W         = 16,
    parameter int GRANULE_BYTES = 128,
    localparam int PW      = $clog2(NPORTS),
    localparam int BYTE_LG = $clog2(WORD_W / 8),
    localparam int GRAN_LG = $clog2(GRANULE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NPORTS-1:0] cfg_mask,
    input  logic [2:0]        cfg_op,
    input  logic [1:0]        cfg_mode,
    input  logic [PW-1:0]     cfg_root,
    input  logic [LEN_W-1:0]  cfg_len_bytes,
    input  logic              adv,
    output logic [NPORTS-1:0] mask_q,
    output logic [2:0]        op_q,
    output logic [1:0]        mode_q,
    output logic [PW-1:0]     root_q,
    output logic [PW-1:0]     scat_q,
    output logic              busy,
    output logic              done,
    output logic              err
);
    import sru_pkg::*;

    sru_state_e        state_q, state_d;
    logic [LEN_W-1:0]  words_q, widx_q, slice_len_q, slice_cnt_q;
    logic              bad, last;

    assign bad = (cfg_len_bytes[GRAN_LG-1:0] != '0) || (cfg_len_bytes == '0) ||
                 (cfg_mask == '0) || (cfg_op > OP_XOR) || (cfg_mode == 2'd3);
    assign last = (widx_q == words_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = bad ? ST_REJ : ST_RUN;
            ST_RUN:  if (adv && last) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            ST_REJ:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        err  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy = 1'b1;
            ST_FIN:  done = 1'b1;
            ST_REJ:  err  = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q      <= '0;
            op_q        <= '0;
            mode_q      <= '0;
            root_q      <= '0;
            words_q     <= '0;
            widx_q      <= '0;
            slice_len_q <= '0;
            slice_cnt_q <= '0;
            scat_q      <= '0;
        end else if (state_q == ST_IDLE && start && !bad) begin
            mask_q      <= cfg_mask;
            op_q        <= cfg_op;
            mode_q      <= cfg_mode;
            root_q      <= cfg_root;
            words_q     <= cfg_len_bytes >> BYTE_LG;
            slice_len_q <= cfg_len_bytes >> (BYTE_LG + PW);
            widx_q      <= '0;
            slice_cnt_q <= '0;
            scat_q      <= '0;
        end else if (state_q == ST_RUN && adv) begin
            widx_q <= widx_q + 1'b1;
            if (slice_cnt_q == slice_len_q - 1'b1) begin
                slice_cnt_q <= '0;
                scat_q      <= scat_q + 1'b1;
            end else begin
                slice_cnt_q <= slice_cnt_q + 1'b1;
            end
        end
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && adv && last) |=> done);   // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);   // R8
    AST_SCATTER_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && mode_q == DLV_SCATTER) |-> (scat_q >= $past(scat_q)));   // R6

endmodule

// File: rtl/sru_route.sv
module sru_route #(
    parameter int NPORTS = 4,
    localparam int PW = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [1:0]        mode,
    input  logic [PW-1:0]     root,
    input  logic [PW-1:0]     scat_port,
    input  logic [NPORTS-1:0] out_ready,
    input  logic              mc_ready,
    output logic [NPORTS-1:0] out_valid,
    output logic              mc_valid,
    output logic              sink_ready
);
    import sru_pkg::*;

    always_comb begin
        out_valid  = '0;
        mc_valid   = 1'b0;
        sink_ready = 1'b0;
        if (go) begin
            case (mode)
                DLV_ROOT: begin
                    out_valid[root] = 1'b1;
                    sink_ready      = out_ready[root];
                end
                DLV_MCAST: begin
                    mc_valid   = 1'b1;
                    sink_ready = mc_ready;
                end
                DLV_SCATTER: begin
                    out_valid[scat_port] = 1'b1;
                    sink_ready           = out_ready[scat_port];
                end
                default: ;
            endcase
        end
    end

    AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mc_valid, out_valid}));   // R4

endmodule

// File: rtl/sru_top.sv
module sru_top #(
    parameter int NPORTS        = 4,
    parameter int WORD_W        = 64,
    parameter int LANE_W        = 16,
    parameter int LEN_W         = 16,
    parameter int GRANULE_BYTES = 128,
    localparam int PW = $clog2(NPORTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NPORTS-1:0]        cfg_mask,
    input  logic [2:0]               cfg_op,
    input  logic [1:0]               cfg_mode,
    input  logic [PW-1:0]            cfg_root,
    input  logic [LEN_W-1:0]         cfg_len_bytes,
    input  logic [NPORTS-1:0]        in_valid,
    input  logic [NPORTS*WORD_W-1:0] in_data,
    output logic [NPORTS-1:0]        in_ready,
    output logic [NPORTS-1:0]        out_valid,
    output logic [WORD_W-1:0]        out_data,
    input  logic [NPORTS-1:0]        out_ready,
    output logic                     mc_valid,
    output logic [WORD_W-1:0]        mc_data,
    input  logic                     mc_ready,
    output logic                     busy,
    output logic                     done,
    output logic                     err
);
    logic [NPORTS-1:0] mask_q;
    logic [2:0]        op_q;
    logic [1:0]        mode_q;
    logic [PW-1:0]     root_q, scat_q;
    logic              aligned, go, sink_ready, adv;
    logic [WORD_W-1:0] result;

    assign aligned  = ((in_valid & mask_q) == mask_q);
    assign go       = busy && aligned;
    assign adv      = go && sink_ready;
    assign in_ready = {NPORTS{adv}} & mask_q;
    assign out_data = result;
    assign mc_data  = result;

    sru_ctrl #(
        .NPORTS(NPORTS), .WORD_W(WORD_W), .LEN_W(LEN_W), .GRANULE_BYTES(GRANULE_BYTES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_mask(cfg_mask), .cfg_op(cfg_op), .cfg_mode(cfg_mode),
        .cfg_root(cfg_root), .cfg_len_bytes(cfg_len_bytes), .adv(adv),
        .mask_q(mask_q), .op_q(op_q), .mode_q(mode_q), .root_q(root_q),
        .scat_q(scat_q), .busy(busy), .done(done), .err(err)
    );

    sru_combine #(.NPORTS(NPORTS), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_comb (
        .op(op_q), .mask(mask_q), .din(in_data), .y(result)
    );

    sru_route #(.NPORTS(NPORTS)) u_route (
        .clk(clk), .rst_n(rst_n), .go(go), .mode(mode_q), .root(root_q),
        .scat_port(scat_q), .out_ready(out_ready), .mc_ready(mc_ready),
        .out_valid(out_valid), .mc_valid(mc_valid), .sink_ready(sink_ready)
    );

    AST_OUT_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_valid) || mc_valid) |-> ((in_valid & mask_q) == mask_q));   // R1
    AST_NO_STRAY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~mask_q) == '0);   // R2
    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (in_ready == '0 && out_valid == '0 && !mc_valid));   // R7
    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (((|out_valid) || mc_valid) && !sink_ready) |-> (in_ready == '0));   // R9

endmodule

// File: tb/sru_top_bench.sv
`timescale 1ns/1ps
module sru_top_bench;
    localparam int NP = 4;
    localparam int W  = 64;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NP-1:0] cfg_mask = '0;
    logic [2:0]    cfg_op = '0;
    logic [1:0]    cfg_mode = '0;
    logic [1:0]    cfg_root = '0;
    logic [15:0]   cfg_len_bytes = '0;
    logic [NP-1:0] in_valid = '0;
    logic [NP*W-1:0] in_data = '0;
    logic [NP-1:0] in_ready, out_valid, out_ready;
    logic [W-1:0]  out_data, mc_data;
    logic          mc_valid, mc_ready, busy, done, err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sru_top u_sru_top (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mask(cfg_mask),
        .cfg_op(cfg_op), .cfg_mode(cfg_mode), .cfg_root(cfg_root),
        .cfg_len_bytes(cfg_len_bytes), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .mc_valid(mc_valid), .mc_data(mc_data),
        .mc_ready(mc_ready), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] gen(int p, int idx, int seed);
        logic [W-1:0] w;
        for (int l = 0; l < W/LW; l++)
            w[l*LW +: LW] = 16'((p + 1) * 4099 + idx * 733 + l * 9001 + seed * 37)
                            ^ ((p % 2 == 1) ? 16'h8000 : 16'h0000);
        return w;
    endfunction

    function automatic logic [W-1:0] model(logic [2:0] op, logic [NP-1:0] mask,
                                           int idx, int seed);
        logic [W-1:0] acc, w;
        logic signed [LW-1:0] a, b, r;
        bit have;
        acc = '0;
        have = 0;
        for (int p = 0; p < NP; p++) begin
            if (mask[p]) begin
                w = gen(p, idx, seed);
                if (!have) begin
                    acc = w;
                    have = 1;
                end else begin
                    for (int l = 0; l < W/LW; l++) begin
                        a = acc[l*LW +: LW];
                        b = w[l*LW +: LW];
                        case (op)
                            3'd0: r = a + b;
                            3'd1: r = (a > b) ? a : b;
                            3'd2: r = (a < b) ? a : b;
                            3'd3: r = a & b;
                            3'd4: r = a | b;
                            default: r = a ^ b;
                        endcase
                        acc[l*LW +: LW] = r;
                    end
                end
            end
        end
        return acc;
    endfunction

    task automatic do_run(input logic [NP-1:0] mask, input logic [2:0] op,
                          input logic [1:0] mode, input logic [1:0] root,
                          input int bytes, input logic [NP-1:0] stall_ports,
                          input bit bp, input int seed, input string tag);
        int words = bytes / 8;
        int got = 0;
        int widx = 0;
        int cyc = 0;
        int dest, edest;
        bit leak = 0;
        bit misalign = 0;
        bit rdy_mismatch = 0;
        logic [W-1:0] d;
        cfg_mask = mask; cfg_op = op; cfg_mode = mode; cfg_root = root;
        cfg_len_bytes = 16'(bytes);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, tag, "busy after accept", busy, 1);
        while (got < words && cyc < 5000) begin
            for (int p = 0; p < NP; p++) begin
                if (mask[p]) begin
                    in_valid[p] = (widx < words) && !(stall_ports[p] && (cyc % 3 != 0));
                    in_data[p*W +: W] = gen(p, widx, seed);
                end else begin
                    in_valid[p] = 1'b1;
                    in_data[p*W +: W] = 64'hFFFF_7FFF_8000_0001 ^ 64'(cyc);
                end
            end
            out_ready = bp ? {NP{cyc % 2 == 0}} : '1;
            mc_ready  = bp ? (cyc % 2 == 0) : 1'b1;
            #1;
            if ((in_ready & ~mask) != '0) leak = 1;
            if ((in_ready != '0) && ((in_valid & mask) != mask)) misalign = 1;
            dest = -1;
            d = '0;
            if (mc_valid && mc_ready) begin
                dest = NP; d = mc_data;
            end else begin
                for (int p = 0; p < NP; p++)
                    if (out_valid[p] && out_ready[p]) begin
                        dest = p; d = out_data;
                    end
            end
            if (dest >= 0) begin
                if (in_ready != mask) rdy_mismatch = 1;
                if (mode == 2'd0) edest = root;
                else if (mode == 2'd1) edest = NP;
                else edest = got / (words / NP);
                chk(d == model(op, mask, got, seed), tag, $sformatf("word %0d data", got),
                    d, model(op, mask, got, seed));
                chk(dest == edest, tag, $sformatf("word %0d destination", got), dest, edest);
                got++;
            end else if (in_ready != '0) begin
                rdy_mismatch = 1;
            end
            if (in_ready != '0) widx++;
            cyc++;
            @(negedge clk);
        end
        in_valid = '0;
        chk(got == words, tag, "result word count", got, words);
        chk(done == 1'b1, "R8", "done one cycle after last word", done, 1);
        chk(!leak, "R2", "non-member saw ready", leak, 0);
        chk(!misalign, "R1", "consumed with a member invalid", misalign, 0);
        chk(!rdy_mismatch, "R1", "ready not on all members at handshake", rdy_mismatch, 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8", "done single cycle and idle",
            {done, busy}, 0);
    endtask

    task automatic do_reject(input logic [NP-1:0] mask, input logic [2:0] op,
                             input logic [1:0] mode, input int bytes, input string what);
        cfg_mask = mask; cfg_op = op; cfg_mode = mode; cfg_root = 2'd0;
        cfg_len_bytes = 16'(bytes);
        in_valid = '1;
        out_ready = '1;
        mc_ready = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1 && busy == 1'b0, "R7", {what, " err pulse"}, {err, busy}, 2'b10);
        chk(in_ready == '0 && out_valid == '0 && !mc_valid, "R7", {what, " no traffic"},
            {in_ready, out_valid, mc_valid}, 0);
        @(negedge clk);
        chk(err == 1'b0 && busy == 1'b0 && out_valid == '0 && !mc_valid, "R7",
            {what, " back to idle"}, {err, busy, out_valid, mc_valid}, 0);
        in_valid = '0;
    endtask

    task automatic test_reset;
        chk(out_valid == '0 && !mc_valid && in_ready == '0, "R10", "outputs quiet in reset",
            {out_valid, mc_valid, in_ready}, 0);
        chk(!busy && !done && !err, "R10", "status low in reset", {busy, done, err}, 0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        out_ready = '1;
        mc_ready = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // R3 R4: wrapping sum, all members, delivered to root port 2
        do_run(4'b1111, 3'd0, 2'd0, 2'd2, 128, 4'b0000, 0, 1, "R4");
        // R1 R2 R5: signed max, port 2 outside mask with junk, staggered members, multicast
        do_run(4'b1011, 3'd1, 2'd1, 2'd0, 256, 4'b1001, 0, 5, "R5");
        // R6 R9: signed min, scatter of 48 words into 12-word slices, sink stalls
        do_run(4'b1111, 3'd2, 2'd2, 2'd0, 384, 4'b0000, 1, 9, "R6");
        // R3: bitwise ops, partial masks
        do_run(4'b0110, 3'd5, 2'd0, 2'd0, 128, 4'b0100, 0, 13, "R3");
        do_run(4'b1101, 3'd3, 2'd1, 2'd0, 128, 4'b0000, 1, 17, "R3");
        do_run(4'b1010, 3'd4, 2'd2, 2'd0, 256, 4'b1000, 0, 21, "R3");
        // R9: root delivery under stall with staggered inputs
        do_run(4'b0111, 3'd0, 2'd0, 2'd3, 128, 4'b0010, 1, 27, "R9");
        // R7: refusals
        do_reject(4'b1111, 3'd0, 2'd0, 100, "length not granule multiple");
        do_reject(4'b1111, 3'd0, 2'd0, 0, "zero length");
        do_reject(4'b0000, 3'd0, 2'd0, 128, "empty mask");
        do_reject(4'b1111, 3'd6, 2'd0, 128, "bad op");
        do_reject(4'b1111, 3'd0, 2'd3, 128, "bad mode");
        // unit still works after refusals
        do_run(4'b1111, 3'd1, 2'd2, 2'd0, 128, 4'b0110, 0, 31, "R6");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule